// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This block decides when the core of a small microcontroller sleeps and which clock domains stay alive while it does. The CPU raises a one-cycle sleep request together with a 3-bit mode code. The controller then drops the clock enables of the CPU, the program memory and, depending on the mode, the I/O domain. In the light sleep mode the I/O clock keeps running and any wake source brings the core back. In the ADC quiet mode the I/O clock also stops, so the ADC sees a quieter supply, and only a fixed subset of sources may end the sleep.

A software-owned "brown-out off in sleep" bit lets firmware switch the brown-out detector off for the length of a sleep. The bit can only be changed by a two-step timed write. When the detector was off, wake-up waits a long, parameterised number of cycles so that the detector is settled before the CPU clock restarts. Otherwise a short fixed delay is used. On entry to either mode, if the ADC is enabled, the block emits a one-cycle conversion-start pulse.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: Out of reset all three clock enables and the brown-out enable are 1, the conversion-start pulse is 0 and the brown-out-off bit reads 0.
- R2: A sleep request with mode 3'b000 (light sleep) clears the CPU and program-memory clock enables in the cycle after the request edge, and the I/O clock enable stays 1.
- R3: A sleep request with mode 3'b001 (ADC quiet) clears the CPU, program-memory and I/O clock enables in the cycle after the request edge.
- R4: Mode codes 3'b010 to 3'b111 behave exactly as light sleep.
- R5: The conversion-start output is high for exactly the one cycle after the request edge, and only if the ADC-enable input was 1 at that edge.
- R6: In light sleep, any of the 12 wake-source bits ends the sleep.
- R7: In ADC quiet sleep, only wake-source bits 0 to 9 end the sleep. Bit 0 is ADC done, 1 is external reset, 2 is watchdog reset, 3 is watchdog interrupt, 4 is brown-out reset, 5 is two-wire address match, 6 is async timer interrupt, 7 is memory-write ready, 8 is external level interrupt and 9 is pin change. Bits 10 (timer overflow) and 11 (serial/other) are ignored and the clocks stay off.
- R8: With the brown-out-off bit at 0, the clock enables return to 1 exactly FAST_WAKE_CYC cycles after the edge at which the wake was sampled, and the brown-out enable stays 1 through the whole sleep.
- R9: With the brown-out-off bit at 1, the brown-out enable is 0 from the first sleep cycle, returns to 1 in the cycle after the wake edge, and the clock enables return BOD_WAKE_CYC cycles after the wake edge.
- R10: The brown-out-off bit changes only by a write with enable=0 that lands 1 to UNLOCK_CYC cycles after an unlock write, which has bit=1 and enable=1 together. All other writes leave it unchanged, and an accepted write closes the window.
- R11: A sleep request while not awake and a wake source while awake have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | One-cycle sleep request from the CPU |
| sleep_mode_i | input | 3 | Sleep mode code |
| adc_en_i | input | 1 | ADC enabled; arms the conversion start on entry |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_bods_i | input | 1 | Write data: brown-out-off-in-sleep bit |
| ctrl_bodse_i | input | 1 | Write data: unlock enable bit |
| wake_src_i | input | 12 | Wake source levels, bit positions as in R7 |
| bods_o | output | 1 | Current brown-out-off-in-sleep bit |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| flash_clk_en_o | output | 1 | Program-memory clock enable |
| io_clk_en_o | output | 1 | I/O clock enable |
| bod_en_o | output | 1 | Brown-out detector enable |
| adc_start_o | output | 1 | Conversion-start pulse |

## Verification
The bench builds the block with BOD_WAKE_CYC=40, FAST_WAKE_CYC=4 and UNLOCK_CYC=4. The short long-delay lets the whole settle count be walked cycle by cycle and measured to the exact edge, rather than taken on trust at the default of 15000 cycles. The small unlock window lets the bench land writes on its last accepted cycle and on the first rejected one.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WAKE   = 2'd2
  } pm_state_e;

  localparam int unsigned WAKE_W = 12;

  localparam logic [2:0] MODE_LIGHT = 3'b000;
  localparam logic [2:0] MODE_QUIET = 3'b001;

  // bit positions of wake sources
  localparam int unsigned WS_ADC_DONE  = 0;
  localparam int unsigned WS_EXT_RST   = 1;
  localparam int unsigned WS_WDT_RST   = 2;
  localparam int unsigned WS_WDT_IRQ   = 3;
  localparam int unsigned WS_BO_RST    = 4;
  localparam int unsigned WS_TWI_MATCH = 5;
  localparam int unsigned WS_ATMR_IRQ  = 6;
  localparam int unsigned WS_MEM_RDY   = 7;
  localparam int unsigned WS_EXT_LVL   = 8;
  localparam int unsigned WS_PIN_CHG   = 9;
  localparam int unsigned WS_TMR_OVF   = 10;
  localparam int unsigned WS_SER_MISC  = 11;

  localparam logic [WAKE_W-1:0] QUIET_WAKE_MASK =
      (WAKE_W'(1) << WS_ADC_DONE)  | (WAKE_W'(1) << WS_EXT_RST)  |
      (WAKE_W'(1) << WS_WDT_RST)   | (WAKE_W'(1) << WS_WDT_IRQ)  |
      (WAKE_W'(1) << WS_BO_RST)    | (WAKE_W'(1) << WS_TWI_MATCH)|
      (WAKE_W'(1) << WS_ATMR_IRQ)  | (WAKE_W'(1) << WS_MEM_RDY)  |
      (WAKE_W'(1) << WS_EXT_LVL)   | (WAKE_W'(1) << WS_PIN_CHG);
endpackage

// File: rtl/sleep_bods_unlock.sv
module sleep_bods_unlock #(
  parameter int unsigned UNLOCK_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic bods_i,
  input  logic bodse_i,
  output logic bods_o
);
  localparam int unsigned UW = $clog2(UNLOCK_CYC + 1);

  logic [UW-1:0] win_q;
  logic          bods_q;
  logic          unlock_wr, data_wr;

  assign unlock_wr = wr_i & bods_i & bodse_i;
  assign data_wr   = wr_i & ~bodse_i & (win_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      bods_q <= 1'b0;
    end else if (unlock_wr) begin
      win_q <= UW'(UNLOCK_CYC);
    end else if (data_wr) begin
      bods_q <= bods_i;
      win_q  <= '0;
    end else if (win_q != '0) begin
      win_q <= win_q - 1'b1;
    end
  end

  assign bods_o = bods_q;

  p_bods_timed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bods_q) |-> ($past(wr_i) && !$past(bodse_i) && ($past(win_q) != '0)));

  p_win_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q <= UW'(UNLOCK_CYC)));

  p_win_drains_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0 && !wr_i) |=> (win_q == $past(win_q) - 1'b1));
endmodule

// File: rtl/sleep_wake_filter.sv
module sleep_wake_filter
  import sleep_pkg::*;
(
  input  logic              quiet_i,
  input  logic [WAKE_W-1:0] src_i,
  output logic              hit_o
);
  logic [WAKE_W-1:0] pass;

  for (genvar g = 0; g < WAKE_W; g++) begin : g_src
    assign pass[g] = src_i[g] & (~quiet_i | QUIET_WAKE_MASK[g]);
  end

  assign hit_o = |pass;
endmodule

// File: rtl/sleep_wake_timer.sv
module sleep_wake_timer #(
  parameter int unsigned BOD_WAKE_CYC  = 15000,
  parameter int unsigned FAST_WAKE_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  output logic done_o
);
  localparam int unsigned MAXC = (BOD_WAKE_CYC > FAST_WAKE_CYC) ? BOD_WAKE_CYC : FAST_WAKE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  initial begin
    if (BOD_WAKE_CYC < 1 || FAST_WAKE_CYC < 1) $error("wake delays must be at least 1");
  end

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= long_i ? CW'(BOD_WAKE_CYC) : CW'(FAST_WAKE_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == CW'(1));

  p_count_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_load_value_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == ($past(long_i) ? CW'(BOD_WAKE_CYC) : CW'(FAST_WAKE_CYC))));
endmodule

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl
  import sleep_pkg::*;
#(
  parameter int unsigned BOD_WAKE_CYC  = 15000,
  parameter int unsigned FAST_WAKE_CYC = 6,
  parameter int unsigned UNLOCK_CYC    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic [2:0]        sleep_mode_i,
  input  logic              adc_en_i,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_bods_i,
  input  logic              ctrl_bodse_i,
  input  logic [WAKE_W-1:0] wake_src_i,
  output logic              bods_o,
  output logic              cpu_clk_en_o,
  output logic              flash_clk_en_o,
  output logic              io_clk_en_o,
  output logic              bod_en_o,
  output logic              adc_start_o
);
  pm_state_e state_q;
  logic quiet_q, boff_q;
  logic cpu_en_q, flash_en_q, io_en_q, bod_en_q, adc_start_q;
  logic bods, wake_hit, tmr_load, tmr_done, req_quiet;

  sleep_bods_unlock #(.UNLOCK_CYC(UNLOCK_CYC)) u_unlock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr_i),
    .bods_i  (ctrl_bods_i),
    .bodse_i (ctrl_bodse_i),
    .bods_o  (bods)
  );

  sleep_wake_filter u_filter (
    .quiet_i (quiet_q),
    .src_i   (wake_src_i),
    .hit_o   (wake_hit)
  );

  sleep_wake_timer #(
    .BOD_WAKE_CYC  (BOD_WAKE_CYC),
    .FAST_WAKE_CYC (FAST_WAKE_CYC)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .long_i (boff_q),
    .done_o (tmr_done)
  );

  // unknown codes fall back to light sleep
  assign req_quiet = (sleep_mode_i == MODE_QUIET);
  assign tmr_load  = (state_q == ST_SLEEP) && wake_hit;

  // every enable is a flop: no combinational path to the gates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ACTIVE;
      quiet_q     <= 1'b0;
      boff_q      <= 1'b0;
      cpu_en_q    <= 1'b1;
      flash_en_q  <= 1'b1;
      io_en_q     <= 1'b1;
      bod_en_q    <= 1'b1;
      adc_start_q <= 1'b0;
    end else begin
      adc_start_q <= 1'b0;
      unique case (state_q)
        ST_ACTIVE: if (sleep_req_i) begin
          state_q     <= ST_SLEEP;
          quiet_q     <= req_quiet;
          boff_q      <= bods;
          cpu_en_q    <= 1'b0;
          flash_en_q  <= 1'b0;
          io_en_q     <= ~req_quiet;
          bod_en_q    <= ~bods;
          adc_start_q <= adc_en_i;
        end
        ST_SLEEP: if (wake_hit) begin
          state_q  <= ST_WAKE;
          bod_en_q <= 1'b1;
        end
        ST_WAKE: if (tmr_done) begin
          state_q    <= ST_ACTIVE;
          cpu_en_q   <= 1'b1;
          flash_en_q <= 1'b1;
          io_en_q    <= 1'b1;
        end
        default: state_q <= ST_ACTIVE;
      endcase
    end
  end

  assign bods_o         = bods;
  assign cpu_clk_en_o   = cpu_en_q;
  assign flash_clk_en_o = flash_en_q;
  assign io_clk_en_o    = io_en_q;
  assign bod_en_o       = bod_en_q;
  assign adc_start_o    = adc_start_q;

  p_io_needs_cpu_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_clk_en_o |-> !cpu_clk_en_o);

  p_adc_one_shot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  p_adc_on_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> $fell(cpu_clk_en_o));

  p_bod_on_when_running_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> bod_en_o);

  p_wake_holds_gates_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |-> (!cpu_clk_en_o && !flash_clk_en_o));

  p_quiet_filter_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && quiet_q && ((wake_src_i & QUIET_WAKE_MASK) == '0))
      |=> (state_q == ST_SLEEP));

  p_req_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && !wake_hit) |=> ($stable(io_clk_en_o) && $stable(bod_en_o)));
endmodule

// File: tb/sleep_clkgate_ctrl_tb.sv
module sleep_clkgate_ctrl_tb;
  localparam int BODC = 40;
  localparam int FASTC = 4;
  localparam int UNLK = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_req = 0, adc_en = 0, ctrl_wr = 0, ctrl_bods = 0, ctrl_bodse = 0;
  logic [2:0] sleep_mode = '0;
  logic [11:0] wake_src = '0;
  logic bods_o, cpu_en, flash_en, io_en, bod_en, adc_start;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  sleep_clkgate_ctrl #(
    .BOD_WAKE_CYC(BODC), .FAST_WAKE_CYC(FASTC), .UNLOCK_CYC(UNLK)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .sleep_mode_i(sleep_mode),
    .adc_en_i(adc_en), .ctrl_wr_i(ctrl_wr), .ctrl_bods_i(ctrl_bods), .ctrl_bodse_i(ctrl_bodse),
    .wake_src_i(wake_src), .bods_o(bods_o), .cpu_clk_en_o(cpu_en), .flash_clk_en_o(flash_en),
    .io_clk_en_o(io_en), .bod_en_o(bod_en), .adc_start_o(adc_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference: 0 awake, 1 asleep, 2 waking
  int m_st, m_cnt, m_win;
  bit m_quiet, m_boff, m_bods;
  bit m_cpu, m_flash, m_io, m_bod, m_adc;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_win = 0; m_quiet = 0; m_boff = 0; m_bods = 0;
      m_cpu = 1; m_flash = 1; m_io = 1; m_bod = 1; m_adc = 0;
    end else begin
      m_adc = 0;
      if (m_st == 0) begin
        if (sleep_req) begin
          m_st = 1; m_quiet = (sleep_mode == 3'b001); m_boff = m_bods;
          m_cpu = 0; m_flash = 0; m_io = !m_quiet; m_bod = !m_bods; m_adc = adc_en;
        end
      end else if (m_st == 1) begin
        if (m_quiet ? (wake_src[9:0] != 0) : (wake_src != 0)) begin
          m_st = 2; m_cnt = m_boff ? BODC : FASTC; m_bod = 1;
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin m_st = 0; m_cpu = 1; m_flash = 1; m_io = 1; end
      end
      if (ctrl_wr && ctrl_bods && ctrl_bodse) m_win = UNLK;
      else if (ctrl_wr && !ctrl_bodse && m_win > 0) begin m_bods = ctrl_bods; m_win = 0; end
      else if (m_win > 0) m_win--;
    end
  end

  always @(negedge clk) begin
    if (rst_ni)
      chk(cur_req, {cpu_en, flash_en, io_en, bod_en, adc_start, bods_o},
                   {m_cpu, m_flash, m_io, m_bod, m_adc, m_bods});
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_sleep(input logic [2:0] mode, input logic adc);
    sleep_req = 1; sleep_mode = mode; adc_en = adc;
    @(negedge clk);
    sleep_req = 0; adc_en = 0;
  endtask

  task automatic ctrl_write(input logic b, input logic e);
    ctrl_wr = 1; ctrl_bods = b; ctrl_bodse = e;
    @(negedge clk);
    ctrl_wr = 0; ctrl_bods = 0; ctrl_bodse = 0;
  endtask

  // drive wake source, count negedges until CPU clock returns
  task automatic wake_measure(input int idx, input int dly, input string req, input bit bod_chk);
    int n = 0;
    wake_src[idx] = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (n == 1 && bod_chk) chk(req, bod_en, 1);
    end while (!cpu_en && n < 1000);
    wake_src = '0;
    chk(req, n, dly + 1);
  endtask

  initial begin
    tick(2);
    cur_req = "R1";
    chk("R1", {cpu_en, flash_en, io_en, bod_en}, 4'hF);
    chk("R1", {adc_start, bods_o}, 0);
    rst_ni = 1;
    tick(2);

    cur_req = "R2";
    enter_sleep(3'b000, 1'b1);
    chk("R2", {cpu_en, flash_en, io_en}, 3'b001);
    chk("R5", adc_start, 1);
    tick(1);
    chk("R5", adc_start, 0);
    cur_req = "R6";
    tick(2);
    wake_measure(10, FASTC, "R6", 1'b0);
    tick(2);

    cur_req = "R3";
    enter_sleep(3'b001, 1'b0);
    chk("R3", {cpu_en, flash_en, io_en}, 3'b000);
    chk("R5", adc_start, 0);
    cur_req = "R7";
    wake_src[10] = 1; wake_src[11] = 1;
    tick(6);
    chk("R7", {cpu_en, io_en}, 0);
    wake_src = '0;
    cur_req = "R11";
    sleep_req = 1; sleep_mode = 3'b000;
    tick(1);
    sleep_req = 0;
    tick(1);
    chk("R11", io_en, 0);
    cur_req = "R8";
    wake_measure(0, FASTC, "R8", 1'b0);
    chk("R8", bod_en, 1);
    tick(2);

    cur_req = "R4";
    enter_sleep(3'b110, 1'b1);
    chk("R4", {cpu_en, flash_en, io_en}, 3'b001);
    chk("R5", adc_start, 1);
    tick(3);
    wake_measure(11, FASTC, "R4", 1'b0);
    enter_sleep(3'b111, 1'b0);
    chk("R4", io_en, 1);
    wake_measure(9, FASTC, "R4", 1'b0);

    cur_req = "R11";
    wake_src = '1;
    tick(3);
    chk("R11", {cpu_en, flash_en, io_en}, 3'b111);
    wake_src = '0;
    tick(1);

    cur_req = "R10";
    ctrl_write(1, 0);
    chk("R10", bods_o, 0);
    ctrl_write(1, 1);
    chk("R10", bods_o, 0);
    tick(UNLK);
    ctrl_write(1, 0);
    chk("R10", bods_o, 0);
    ctrl_write(1, 1);
    tick(UNLK - 1);
    ctrl_write(1, 0);
    chk("R10", bods_o, 1);
    ctrl_write(0, 0);
    chk("R10", bods_o, 1);

    cur_req = "R9";
    enter_sleep(3'b001, 1'b0);
    chk("R9", bod_en, 0);
    tick(3);
    chk("R9", bod_en, 0);
    wake_measure(5, BODC, "R9", 1'b1);
    tick(2);

    cur_req = "R10";
    ctrl_write(1, 1);
    ctrl_write(0, 0);
    chk("R10", bods_o, 0);
    cur_req = "R8";
    enter_sleep(3'b000, 1'b0);
    chk("R8", bod_en, 1);
    wake_measure(3, FASTC, "R8", 1'b0);
    tick(3);
    finish_run();
  end
endmodule